// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits in a small 16-bit processor core and carries it from an accepted interrupt request to the first instruction of the handler. It waits for a safe entry point. For an ordinary instruction that is the cycle in which the instruction finishes. For a block-move, string-store or repeated multiply-accumulate instruction it does not wait: the sequencer tells the execution unit to abandon that instruction partway through.

The entry then follows a fixed order, with every memory access made over a request/ready port:

1. Read the interrupt information word at address zero into an internal scratch register that software cannot see.
2. Copy the flag register, as it stood when the request was taken, into that scratch register.
3. Clear the interrupt-enable, debug and stack-select flags.
4. Push the scratch register and the return address to the stack.
5. Load the priority level of the request into the flag register.
6. Read the handler address from a vector table and hand it to the fetch unit with a one-cycle done pulse.

Wait states stretch the sequence but never change its order. When no wait states occur, the entry time is fixed, so the response time is the rest of the current instruction plus a constant.

When a string instruction was cut short, the saved return address points back at that same instruction, so it restarts after the handler returns. A resume marker reports this case.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset and whenever idle, busy, mem_req, flg_we, done and abort_insn are all low.
- R2: A pending request with neither insn_done nor insn_string high starts nothing: busy stays low and no memory access is made. A pending request sampled with insn_done high starts the sequence on the next cycle.
- R3: A pending request sampled with insn_string high and insn_done low raises abort_insn in that same cycle. The sequence then saves insn_pc as the return address and sets resume_mark. In every other entry the return address is next_pc and resume_mark is 0.
- R4: The first access is a read (mem_we low) at address 0. In the word returned, bits [5:0] hold the interrupt number and bits [10:8] hold the level.
- R5: The first flag write (flg_we) carries the flags captured at entry with bit 6 (interrupt enable), bit 2 (debug) and bit 7 (stack select) cleared. Bit 7 is left unchanged when irq_sw was high at entry and the number is 32 to 63.
- R6: Three stack writes follow, in this order, each one 2 below the one before it. The captured flags go to sp_in-2. The return address bits [19:16], zero-extended, go to sp_in-4. Its bits [15:0] go to sp_in-6. sp_out then equals sp_in-6.
- R7: The second flag write equals the R5 value with bits [14:12] replaced by the request level.
- R8: Two reads follow the stack writes: the low handler word at VEC_BASE+4·number, then the high word at the next address (+2), whose bits [3:0] form handler_pc[19:16]. done is high for exactly one cycle, and handler_pc and sp_out are valid while it is high.
- R9: While mem_rdy is low, mem_req, mem_we, mem_addr and mem_wdata hold steady. Each wait cycle delays done by one cycle.
- R10: With mem_rdy always high, done is high after the ninth rising edge that follows the edge sampling the entry condition.
- R11: Requests and instruction indications arriving while busy are ignored: exactly six accesses and two flag writes occur per entry, and busy falls after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pend | input | 1 | An accepted interrupt request is pending |
| irq_sw | input | 1 | The pending request comes from a software interrupt instruction |
| insn_done | input | 1 | The current instruction completes this cycle |
| insn_string | input | 1 | A suspendable string instruction is executing |
| next_pc | input | 20 | Address of the instruction after the current one |
| insn_pc | input | 20 | Address of the current instruction |
| flg_in | input | 16 | Current flag register |
| sp_in | input | 20 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| abort_insn | output | 1 | Suspend the executing string instruction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes this cycle |
| flg_we | output | 1 | Flag register write strobe |
| flg_wdata | output | 16 | New flag register value |
| done | output | 1 | One-cycle pulse: handler address is valid |
| handler_pc | output | 20 | Handler start address |
| sp_out | output | 20 | Stack pointer after the pushes |
| resume_mark | output | 1 | The last entry suspended a string instruction |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 16-bit data word, a 6-bit interrupt number and a 3-bit level. With these values all 64 vector entries can be reached, including both edges of the software range where the stack-select rule changes (31 to 32, and 63). The sweep crosses every number with three entry kinds (normal completion, string suspension, software interrupt) and three wait-state depths, so every level and every stack and vector address pattern is compared against values computed arithmetically.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int PC_W = 20,
  parameter int DW = 16,
  parameter int AW = 20,
  parameter int NUM_W = 6,
  parameter int LVL_W = 3,
  parameter int LVL_LSB = 8,
  parameter logic [AW-1:0] VEC_BASE = 20'hFFD00,
  parameter int SW_LO = 32,
  parameter int SW_HI = 63,
  parameter int I_BIT = 6,
  parameter int D_BIT = 2,
  parameter int U_BIT = 7,
  parameter int IPL_LSB = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_pend,
  input  logic          irq_sw,
  input  logic          insn_done,
  input  logic          insn_string,
  input  logic [PC_W-1:0] next_pc,
  input  logic [PC_W-1:0] insn_pc,
  input  logic [DW-1:0] flg_in,
  input  logic [AW-1:0] sp_in,
  output logic          busy,
  output logic          abort_insn,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          flg_we,
  output logic [DW-1:0] flg_wdata,
  output logic          done,
  output logic [PC_W-1:0] handler_pc,
  output logic [AW-1:0] sp_out,
  output logic          resume_mark
);
  localparam int HW = PC_W - DW;
  localparam logic [AW-1:0] WSTEP = AW'(2);

  typedef enum logic [3:0] {
    S_IDLE, S_INFO, S_TMPF, S_CLRF, S_PSHF, S_PSHH, S_PSHL, S_IPL, S_VLO, S_VHI, S_DONE
  } st_t;

  st_t st, nxt;
  logic [DW-1:0]    tmp, flg_cap, flg_clr, flg_ipl;
  logic [NUM_W-1:0] num_r;
  logic [LVL_W-1:0] lvl_r;
  logic [PC_W-1:0]  pc_sv, hpc;
  logic [AW-1:0]    sp_r, vec_addr;
  logic             sw_r, mark_r, keep_u, susp, trigger;

  assign susp     = insn_string && !insn_done;
  assign trigger  = (st == S_IDLE) && irq_pend && (insn_done || insn_string);
  assign abort_insn = (st == S_IDLE) && irq_pend && susp;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign keep_u   = sw_r && int'(num_r) >= SW_LO && int'(num_r) <= SW_HI;
  assign vec_addr = VEC_BASE + {{(AW-NUM_W-2){1'b0}}, num_r, 2'b00};

  always_comb begin
    flg_clr = flg_cap;
    flg_clr[I_BIT] = 1'b0;
    flg_clr[D_BIT] = 1'b0;
    if (!keep_u) flg_clr[U_BIT] = 1'b0;
    flg_ipl = flg_clr;
    flg_ipl[IPL_LSB +: LVL_W] = lvl_r;
  end

  assign flg_we    = (st == S_CLRF) || (st == S_IPL);
  assign flg_wdata = (st == S_IPL) ? flg_ipl : flg_clr;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_INFO: mem_req = 1'b1;
      S_PSHF: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_r - WSTEP; mem_wdata = tmp;
      end
      S_PSHH: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_r - WSTEP;
        mem_wdata = {{(DW-HW){1'b0}}, pc_sv[PC_W-1:DW]};
      end
      S_PSHL: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = sp_r - WSTEP; mem_wdata = pc_sv[DW-1:0];
      end
      S_VLO: begin mem_req = 1'b1; mem_addr = vec_addr; end
      S_VHI: begin mem_req = 1'b1; mem_addr = vec_addr + WSTEP; end
      default: ;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (trigger) nxt = S_INFO;
      S_INFO: if (mem_rdy) nxt = S_TMPF;
      S_TMPF: nxt = S_CLRF;
      S_CLRF: nxt = S_PSHF;
      S_PSHF: if (mem_rdy) nxt = S_PSHH;
      S_PSHH: if (mem_rdy) nxt = S_PSHL;
      S_PSHL: if (mem_rdy) nxt = S_IPL;
      S_IPL:  nxt = S_VLO;
      S_VLO:  if (mem_rdy) nxt = S_VHI;
      S_VHI:  if (mem_rdy) nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmp <= '0; flg_cap <= '0; num_r <= '0; lvl_r <= '0;
      pc_sv <= '0; hpc <= '0; sp_r <= '0; sw_r <= 1'b0; mark_r <= 1'b0;
    end else begin
      st <= nxt;
      if (trigger) begin
        pc_sv   <= susp ? insn_pc : next_pc;
        flg_cap <= flg_in;
        sp_r    <= sp_in;
        sw_r    <= irq_sw;
        mark_r  <= susp;
      end
      if (st == S_INFO && mem_rdy) tmp <= mem_rdata;
      if (st == S_TMPF) begin
        num_r <= tmp[NUM_W-1:0];
        lvl_r <= tmp[LVL_LSB +: LVL_W];
        tmp   <= flg_cap;
      end
      if (mem_req && mem_we && mem_rdy) sp_r <= sp_r - WSTEP;
      if (st == S_VLO && mem_rdy) hpc[DW-1:0] <= mem_rdata;
      if (st == S_VHI && mem_rdy) hpc[PC_W-1:DW] <= mem_rdata[HW-1:0];
    end
  end

  assign handler_pc  = hpc;
  assign sp_out      = sp_r;
  assign resume_mark = mark_r;
endmodule

module irq_entry_chk #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int I_BIT = 6,
  parameter int D_BIT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_pend,
  input logic          insn_done,
  input logic          busy,
  input logic          abort_insn,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rdy,
  input logic          flg_we,
  input logic [DW-1:0] flg_wdata,
  input logic          done
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !flg_we && !done);
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && irq_pend && insn_done |=> busy);
  // R3
  abort_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_insn |=> busy && !done);
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_we |-> !flg_wdata[I_BIT] && !flg_wdata[D_BIT]);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R11
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW), .DW(DW), .I_BIT(I_BIT), .D_BIT(D_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .insn_done(insn_done), .busy(busy),
  .abort_insn(abort_insn), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .flg_we(flg_we), .flg_wdata(flg_wdata), .done(done)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam logic [19:0] VEC = 20'hFFD00;
  localparam int WD = 150000;

  logic clk = 0, rst_n = 0;
  logic irq_pend = 0, irq_sw = 0, insn_done = 0, insn_string = 0;
  logic [19:0] next_pc = 0, insn_pc = 0, sp_in = 0;
  logic [15:0] flg_in = 0, mem_rdata = 0;
  logic mem_rdy = 0;
  logic busy, abort_insn, mem_req, mem_we, flg_we, done, resume_mark;
  logic [19:0] mem_addr, handler_pc, sp_out;
  logic [15:0] mem_wdata, flg_wdata;

  irq_entry_seq u0 (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, wait_n = 0, waitc = 0;
  int n_acc = 0, n_flg = 0;
  logic [19:0] acc_a [8];
  logic [15:0] acc_d [8];
  logic        acc_w [8];
  logic [15:0] flg_log [4];
  logic [19:0] h_addr;
  logic [15:0] h_wd, info_w;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_lo(input int m);
    return 16'((m * 16'h0431 + 16'h1234) & 16'hFFFF);
  endfunction

  function automatic logic [3:0] vec_hi(input int m);
    return 4'(m) ^ 4'hA;
  endfunction

  function automatic logic [15:0] model(input logic [19:0] a);
    int off;
    if (a == 20'h0) return info_w;
    if (a >= VEC && a < VEC + 20'd256) begin
      off = int'(a - VEC);
      if (off % 4 == 0) return vec_lo(off / 4);
      if (off % 4 == 2) return {12'h0, vec_hi(off / 4)};
    end
    return 16'hDEAD;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
    if (flg_we && n_flg < 4) begin flg_log[n_flg] = flg_wdata; n_flg++; end
    if (mem_req) begin
      if (waitc == 0) begin h_addr = mem_addr; h_wd = mem_wdata; end
      else chk(mem_addr == h_addr && mem_wdata == h_wd, "R9 hold", 32'(mem_addr), 32'(h_addr));
      if (waitc < wait_n) begin mem_rdy = 0; waitc++; end
      else begin
        mem_rdy = 1; waitc = 0;
        if (n_acc < 8) begin
          acc_a[n_acc] = mem_addr; acc_d[n_acc] = mem_wdata; acc_w[n_acc] = mem_we;
        end
        n_acc++;
        mem_rdata = model(mem_addr);
      end
    end else begin
      mem_rdy = 0; waitc = 0;
    end
  end

  task automatic run(input int n, input int mode, input int lvl, input int wn);
    logic [19:0] pc_exp, sp0;
    logic [15:0] f_in, f5, f7;
    int k;
    bit sw, str;
    sw = (mode == 2); str = (mode == 1);
    wait_n = wn;
    info_w = 16'((lvl << 8) | n);
    f_in = 16'((n * 16'h1357) | 16'h00C4);
    sp0 = 20'h08000 + 20'(n * 32);
    @(negedge clk);
    n_acc = 0; n_flg = 0;
    irq_pend = 1; insn_done = 0; insn_string = 0; irq_sw = sw;
    flg_in = f_in; sp_in = sp0;
    next_pc = 20'h40000 + 20'(n * 291 + mode);
    insn_pc = next_pc - 20'h5;
    repeat (3) @(negedge clk);
    chk(!busy && n_acc == 0, "R2 wait for boundary", 32'(n_acc), 0);
    if (str) insn_string = 1; else insn_done = 1;
    #1;
    chk(abort_insn == str, "R3 abort", 32'(abort_insn), 32'(str));
    pc_exp = str ? insn_pc : next_pc;
    k = 0;
    forever begin
      @(negedge clk);
      insn_string = 0;
      insn_done = k[0];
      if (done) break;
      k++;
      if (k > 200) break;
    end
    chk(k == 9 + 6 * wn, (wn == 0) ? "R10 latency" : "R9 latency", 32'(k), 32'(9 + 6 * wn));
    chk(handler_pc == {vec_hi(n), vec_lo(n)}, "R8 handler", 32'(handler_pc), 32'({vec_hi(n), vec_lo(n)}));
    chk(sp_out == sp0 - 20'd6, "R6 sp_out", 32'(sp_out), 32'(sp0 - 20'd6));
    chk(resume_mark == str, "R3 resume_mark", 32'(resume_mark), 32'(str));
    irq_pend = 0; insn_done = 0;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R1 idle after done", 32'(busy), 0);
    chk(n_acc == 6 && n_flg == 2, "R11 counts", 32'(n_acc * 16 + n_flg), 32'h62);
    chk(acc_a[0] == 0 && !acc_w[0], "R4 info read", 32'(acc_a[0]), 0);
    chk(acc_w[1] && acc_a[1] == sp0 - 20'd2 && acc_d[1] == f_in, "R6 flags push", 32'(acc_d[1]), 32'(f_in));
    chk(acc_w[2] && acc_a[2] == sp0 - 20'd4 && acc_d[2] == {12'h0, pc_exp[19:16]},
        "R6 pc high push", 32'(acc_d[2]), 32'(pc_exp[19:16]));
    chk(acc_w[3] && acc_a[3] == sp0 - 20'd6 && acc_d[3] == pc_exp[15:0],
        "R3 saved pc low", 32'(acc_d[3]), 32'(pc_exp[15:0]));
    chk(!acc_w[4] && acc_a[4] == VEC + 20'(4 * n), "R8 vector low addr", 32'(acc_a[4]), 32'(VEC + 20'(4 * n)));
    chk(!acc_w[5] && acc_a[5] == VEC + 20'(4 * n + 2), "R8 vector high addr", 32'(acc_a[5]), 32'(VEC + 20'(4 * n + 2)));
    f5 = f_in & ~16'h0044;
    if (!(sw && n >= 32)) f5 = f5 & ~16'h0080;
    f7 = (f5 & ~16'h7000) | 16'(lvl << 12);
    chk(flg_log[0] == f5, "R5 flag clear", 32'(flg_log[0]), 32'(f5));
    chk(flg_log[1] == f7, "R7 level load", 32'(flg_log[1]), 32'(f7));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !flg_we && !abort_insn, "R1 reset", 32'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req && !done, "R1 after reset", 32'(mem_req), 0);
    for (int n = 0; n < 64; n++)
      for (int m = 0; m < 3; m++)
        run(n, m, (n * 3 + m) % 8, (n + m) % 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule